// File: doc/BRIEF.md
# Overlay and Color Bar Source Selector

This block builds the 8-bit Y/Cb/Cr pixel stream that feeds a video encoder's level converters. For every pixel it picks one of three sources: the incoming image, a single overlay color chosen by three one-bit color pins, or a luminance-ordered color bar that the block draws itself from the horizontal pixel counter. The bar has priority over the overlay pin, and the overlay pin has priority over the image. Outside the active picture the output is forced to black with neutral chroma.

A two-bit amplitude field scales the overlay color and the bar together in four steps. Scaling acts on the excursion of luma above black and on the offset of each chroma sample from 128, so the smallest step still keeps black black. Writes to this field wait in a pending register and are applied only while vertical blanking is flagged. The bar and overlay enables act at once. Every output is registered one clock after its inputs are sampled.

The source choice is a four-state machine whose state register is updated every clock. The states are BLANK (active low), BAR (active and bar enable), OVERLAY (active, bar enable low, overlay key high) and IMAGE (all other active pixels). Any state moves to any other on the next clock, following those conditions in that order of priority.

Top module: `ovl_bar_select`

## Requirements
- R1: After reset the outputs are Y = 16, Cb = 128, Cr = 128, and the amplitude field holds 00 (100%).
- R2: When `active` is low, the outputs one clock later are Y = 16, Cb = 128, Cr = 128, whatever the enables, the overlay pins and the image input are.
- R3: When `active` is high and both `bar_en` and `ovl_key` are low, the outputs one clock later equal `y_in`, `cb_in` and `cr_in` exactly, with no clipping and no scaling.
- R4: When `active` and `ovl_key` are high and `bar_en` is low, the output is the overlay color with index {R,G,B} (R is bit 2). At 100% the colors are: 7 white (235,128,128), 6 yellow (210,16,146), 3 cyan (170,166,16), 2 green (145,54,34), 5 magenta (106,202,222), 4 red (81,90,240), 1 blue (41,240,110), 0 black (16,128,128), given as (Y,Cb,Cr).
- R5: When `active` and `bar_en` are high, the bar is output and `ovl_key` and the overlay pins have no effect.
- R6: With `pal_mode` = 0 the bar starts at pixel 127 and runs white, yellow, cyan, green, magenta, red, blue, black, with each new color starting at pixels 216, 305, 394, 483, 572, 661 and 750.
- R7: With `pal_mode` = 1 the bar starts at pixel 142, and the same color order switches at pixels 230, 318, 406, 494, 582, 670 and 757.
- R8: In bar mode, pixels below the bar start give Y = 16, Cb = 128, Cr = 128.
- R9: For overlay and bar outputs, with k = 4 − level (level 00..11 → 100%, 75%, 50%, 25%), Y = 16 + floor((Y100 − 16)·k/4) and C = 128 + floor((C100 − 128)·k/4).
- R10: A write on `lvl_we` is held pending. The level in use changes only on a clock where `vblank` is high, and the change shows on the output sampled at that clock or later. A write with `vblank` high takes effect on that same clock.
- R11: Changes of `bar_en` and `ovl_key` take effect on the very next output, with no wait for blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_mode | input | 1 | 0: 858-sample line bar table, 1: 864-sample line bar table |
| pix_cnt | input | 10 | Horizontal pixel counter |
| active | input | 1 | High inside the active picture |
| vblank | input | 1 | High during vertical blanking; the pending level is applied then |
| y_in | input | 8 | Image luma |
| cb_in | input | 8 | Image blue-difference chroma |
| cr_in | input | 8 | Image red-difference chroma |
| ovl_key | input | 1 | Overlay transparency control, 1 selects the overlay color |
| ovl_r | input | 1 | Overlay red bit |
| ovl_g | input | 1 | Overlay green bit |
| ovl_b | input | 1 | Overlay blue bit |
| bar_en | input | 1 | Color bar enable |
| lvl_we | input | 1 | Amplitude field write strobe |
| lvl_wdata | input | 2 | Amplitude field write value |
| y_out | output | 8 | Selected luma |
| cb_out | output | 8 | Selected Cb |
| cr_out | output | 8 | Selected Cr |

## Verification
The assertions assume the image is fed at legal levels wherever luma must stay at or above black, so the luma floor check applies only to generated sources. They also assume that pixels below 16 always lie before the bar start in either mode. The bench keeps `active` low and `vblank` high only on the cycles where it changes the amplitude, so amplitude changes never land in the middle of a sweep. It also drives `pix_cnt` only below the line length of the mode in use.

// File: rtl/obs_pkg.sv
package obs_pkg;

    typedef enum logic [1:0] {
        SRC_BLANK,
        SRC_IMAGE,
        SRC_OVERLAY,
        SRC_BAR
    } src_e;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } ycc_t;

    localparam logic [7:0] Y_BLACK = 8'h10;
    localparam logic [7:0] C_ZERO  = 8'h80;

    // Full-amplitude color for a {R,G,B} index.
    function automatic ycc_t rgb_to_ycc(input logic [2:0] rgb);
        ycc_t c;
        unique case (rgb)
            3'd7: c = '{8'd235, 8'd128, 8'd128};
            3'd6: c = '{8'd210, 8'd16,  8'd146};
            3'd3: c = '{8'd170, 8'd166, 8'd16};
            3'd2: c = '{8'd145, 8'd54,  8'd34};
            3'd5: c = '{8'd106, 8'd202, 8'd222};
            3'd4: c = '{8'd81,  8'd90,  8'd240};
            3'd1: c = '{8'd41,  8'd240, 8'd110};
            default: c = '{Y_BLACK, C_ZERO, C_ZERO};
        endcase
        return c;
    endfunction

    // Bar segment number (0 = leftmost) to {R,G,B} index, luminance order.
    function automatic logic [2:0] seg_to_rgb(input logic [2:0] seg);
        logic [2:0] r;
        unique case (seg)
            3'd0: r = 3'd7;
            3'd1: r = 3'd6;
            3'd2: r = 3'd3;
            3'd3: r = 3'd2;
            3'd4: r = 3'd5;
            3'd5: r = 3'd4;
            3'd6: r = 3'd1;
            default: r = 3'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/obs_bar_index.sv
module obs_bar_index
    import obs_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic [PIX_W-1:0] pix,
    input  logic             pal,
    output logic [2:0]       rgb
);
    localparam int NB = 7;
    localparam int NTSC_START = 127;
    localparam int PAL_START  = 142;
    localparam int NTSC_BND [NB] = '{216, 305, 394, 483, 572, 661, 750};
    localparam int PAL_BND  [NB] = '{230, 318, 406, 494, 582, 670, 757};

    logic [NB-1:0] past_bnd;
    logic          in_bar;
    logic [2:0]    seg;

    for (genvar i = 0; i < NB; i++) begin : g_bnd
        assign past_bnd[i] = pal ? (pix >= PIX_W'(PAL_BND[i]))
                                 : (pix >= PIX_W'(NTSC_BND[i]));
    end

    assign in_bar = pal ? (pix >= PIX_W'(PAL_START)) : (pix >= PIX_W'(NTSC_START));
    assign seg    = 3'($countones(past_bnd));
    assign rgb    = in_bar ? seg_to_rgb(seg) : 3'd0;

endmodule

// File: rtl/obs_level_reg.sv
module obs_level_reg #(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vblank,
    input  logic             we,
    input  logic [LVL_W-1:0] wdata,
    output logic [LVL_W-1:0] lvl
);
    logic [LVL_W-1:0] pend_q;
    logic [LVL_W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (we)
                pend_q <= wdata;
            if (vblank)
                act_q <= we ? wdata : pend_q;
        end
    end

    assign lvl = act_q;

    // R10: the level in use moves only on clocks with vblank high
    p_lvl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vblank) |-> $stable(act_q));

endmodule

// File: rtl/obs_scaler.sv
module obs_scaler
    import obs_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  ycc_t             base,
    input  logic [LVL_W-1:0] lvl,
    output ycc_t             scaled
);
    localparam int K_W = LVL_W + 1;

    logic [K_W-1:0]    k;
    logic [7:0]        dy;
    logic [10:0]       py;
    logic signed [8:0] dcb, dcr;
    logic signed [11:0] kk, pcb, pcr, scb, scr;

    assign k   = K_W'(1 << LVL_W) - K_W'(lvl);
    assign dy  = base.y - Y_BLACK;
    assign py  = 11'(dy) * 11'(k);
    assign dcb = $signed({1'b0, base.cb}) - 9'sd128;
    assign dcr = $signed({1'b0, base.cr}) - 9'sd128;
    assign kk  = $signed(12'(k));
    assign pcb = 12'(dcb) * kk;
    assign pcr = 12'(dcr) * kk;
    assign scb = 12'sd128 + (pcb >>> LVL_W);
    assign scr = 12'sd128 + (pcr >>> LVL_W);

    assign scaled.y  = Y_BLACK + py[LVL_W +: 8];
    assign scaled.cb = scb[7:0];
    assign scaled.cr = scr[7:0];

endmodule

// File: rtl/ovl_bar_select.sv
module ovl_bar_select
    import obs_pkg::*;
#(
    parameter int PIX_W = 10,
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pal_mode,
    input  logic [PIX_W-1:0] pix_cnt,
    input  logic             active,
    input  logic             vblank,
    input  logic [7:0]       y_in,
    input  logic [7:0]       cb_in,
    input  logic [7:0]       cr_in,
    input  logic             ovl_key,
    input  logic             ovl_r,
    input  logic             ovl_g,
    input  logic             ovl_b,
    input  logic             bar_en,
    input  logic             lvl_we,
    input  logic [LVL_W-1:0] lvl_wdata,
    output logic [7:0]       y_out,
    output logic [7:0]       cb_out,
    output logic [7:0]       cr_out
);
    src_e             src_q, src_d;
    ycc_t             img_q;
    logic [2:0]       code_q, code_d;
    logic [2:0]       bar_rgb;
    logic [LVL_W-1:0] lvl;
    ycc_t             gen_col;
    ycc_t             out_c;

    obs_bar_index #(.PIX_W(PIX_W)) u_bar (
        .pix (pix_cnt),
        .pal (pal_mode),
        .rgb (bar_rgb)
    );

    obs_level_reg #(.LVL_W(LVL_W)) u_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .vblank (vblank),
        .we     (lvl_we),
        .wdata  (lvl_wdata),
        .lvl    (lvl)
    );

    obs_scaler #(.LVL_W(LVL_W)) u_scale (
        .base   (rgb_to_ycc(code_q)),
        .lvl    (lvl),
        .scaled (gen_col)
    );

    // Next source: blanking, then bar, then overlay, then image.
    always_comb begin
        if (!active)
            src_d = SRC_BLANK;
        else if (bar_en)
            src_d = SRC_BAR;
        else if (ovl_key)
            src_d = SRC_OVERLAY;
        else
            src_d = SRC_IMAGE;
        code_d = bar_en ? bar_rgb : {ovl_r, ovl_g, ovl_b};
    end

    // State register with the pixel data captured alongside it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= SRC_BLANK;
            img_q  <= '{Y_BLACK, C_ZERO, C_ZERO};
            code_q <= 3'd0;
        end else begin
            src_q  <= src_d;
            img_q  <= '{y_in, cb_in, cr_in};
            code_q <= code_d;
        end
    end

    // Outputs per state.
    always_comb begin
        unique case (src_q)
            SRC_BLANK:   out_c = '{Y_BLACK, C_ZERO, C_ZERO};
            SRC_IMAGE:   out_c = img_q;
            SRC_OVERLAY: out_c = gen_col;
            SRC_BAR:     out_c = gen_col;
        endcase
    end

    assign y_out  = out_c.y;
    assign cb_out = out_c.cb;
    assign cr_out = out_c.cr;

    // R2: blanked input gives black one clock later
    p_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!active) |-> (y_out == 8'h10 && cb_out == 8'h80 && cr_out == 8'h80));

    // R3: image passes unchanged with one clock latency
    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active && !bar_en && !ovl_key) |->
            (y_out == $past(y_in) && cb_out == $past(cb_in) && cr_out == $past(cr_in)));

    // R5, R8: bar wins over overlay; the left edge of the line is black
    p_bar_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(active && bar_en && pix_cnt < PIX_W'(16)) |->
            (y_out == 8'h10 && cb_out == 8'h80 && cr_out == 8'h80));

    // R9: generated colors never drop below black
    p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q != SRC_IMAGE) |-> (y_out >= 8'h10));

endmodule

// File: tb/ovl_bar_select_bench.sv
module ovl_bar_select_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pal_mode = 1'b0;
    logic [9:0] pix_cnt = '0;
    logic       active = 1'b0, vblank = 1'b0;
    logic [7:0] y_in = '0, cb_in = '0, cr_in = '0;
    logic       ovl_key = 1'b0, ovl_r = 1'b0, ovl_g = 1'b0, ovl_b = 1'b0;
    logic       bar_en = 1'b0, lvl_we = 1'b0;
    logic [1:0] lvl_wdata = '0;
    logic [7:0] y_out, cb_out, cr_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ovl_bar_select u_ovl_bar_select (
        .clk(clk), .rst_n(rst_n), .pal_mode(pal_mode), .pix_cnt(pix_cnt),
        .active(active), .vblank(vblank), .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
        .ovl_key(ovl_key), .ovl_r(ovl_r), .ovl_g(ovl_g), .ovl_b(ovl_b),
        .bar_en(bar_en), .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
        .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out)
    );

    function automatic int fdiv4(int v);
        if (v >= 0) return v / 4;
        return -((-v + 3) / 4);
    endfunction

    // Full-amplitude (Y,Cb,Cr) for an {R,G,B} index, packed y<<16|cb<<8|cr.
    function automatic int base_col(int rgb);
        case (rgb)
            7: return (235 << 16) | (128 << 8) | 128;
            6: return (210 << 16) | (16 << 8)  | 146;
            3: return (170 << 16) | (166 << 8) | 16;
            2: return (145 << 16) | (54 << 8)  | 34;
            5: return (106 << 16) | (202 << 8) | 222;
            4: return (81 << 16)  | (90 << 8)  | 240;
            1: return (41 << 16)  | (240 << 8) | 110;
            default: return (16 << 16) | (128 << 8) | 128;
        endcase
    endfunction

    function automatic int scale_col(int c, int lvl);
        int k  = 4 - lvl;
        int y  = 16 + fdiv4(((c >> 16) & 255) - 16) * 0 + fdiv4((((c >> 16) & 255) - 16) * k);
        int cb = 128 + fdiv4((((c >> 8) & 255) - 128) * k);
        int cr = 128 + fdiv4(((c & 255) - 128) * k);
        return (y << 16) | (cb << 8) | cr;
    endfunction

    function automatic int bar_rgb(int p, bit pal);
        int st = pal ? 142 : 127;
        int b [7];
        int order [8] = '{7, 6, 3, 2, 5, 4, 1, 0};
        int s = 0;
        if (pal) b = '{230, 318, 406, 494, 582, 670, 757};
        else     b = '{216, 305, 394, 483, 572, 661, 750};
        if (p < st) return 0;
        for (int i = 0; i < 7; i++) if (p >= b[i]) s++;
        return order[s];
    endfunction

    task automatic check(string req, int exp);
        int got = (int'(y_out) << 16) | (int'(cb_out) << 8) | int'(cr_out);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %06h expected %06h", req, got, exp);
        end
    endtask

    // Drive at the falling edge, let the rising edge capture, sample just after.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive_pixel(bit act, bit bar, bit key, int rgb, int p,
                               int yv, int cbv, int crv);
        @(negedge clk);
        active = act; bar_en = bar; ovl_key = key;
        {ovl_r, ovl_g, ovl_b} = 3'(rgb);
        pix_cnt = 10'(p); y_in = 8'(yv); cb_in = 8'(cbv); cr_in = 8'(crv);
        vblank = 1'b0; lvl_we = 1'b0;
        step();
    endtask

    task automatic set_level(int l);
        @(negedge clk);
        active = 1'b0; vblank = 1'b1; lvl_we = 1'b1; lvl_wdata = 2'(l);
        step();
        @(negedge clk);
        vblank = 1'b0; lvl_we = 1'b0;
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int blk = (16 << 16) | (128 << 8) | 128;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", blk);
        @(negedge clk) rst_n = 1'b1;
        step();
        check("R1 after release", blk);

        // R2: blanking beats every source
        for (int i = 0; i < 16; i++) begin
            drive_pixel(1'b0, i[0], i[1], i[3:1], 300 + i, 200, 30, 220);
            check("R2 blank", blk);
        end

        // R3: image pass-through, at a reduced level to show no scaling
        set_level(2);
        for (int v = 0; v < 256; v++) begin
            drive_pixel(1'b1, 1'b0, 1'b0, v % 8, v, v, 255 - v, v ^ 8'h5A);
            check("R3 pass", (v << 16) | ((255 - v) << 8) | (v ^ 8'h5A));
        end

        // R4, R9: overlay colors at every level
        for (int l = 0; l < 4; l++) begin
            set_level(l);
            for (int c = 0; c < 8; c++) begin
                drive_pixel(1'b1, 1'b0, 1'b1, c, 400, 1, 2, 3);
                check("R4 R9 overlay", scale_col(base_col(c), l));
            end
        end

        // R5, R6, R7, R8, R9: bar sweeps with the overlay key held high
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l < 4; l++) begin
                set_level(l);
                @(negedge clk) pal_mode = m[0];
                for (int p = 0; p < (m ? 864 : 858); p++) begin
                    drive_pixel(1'b1, 1'b1, 1'b1, 4, p, 99, 99, 99);
                    check(m ? "R7 R5 R8 bar pal" : "R6 R5 R8 bar ntsc",
                          scale_col(base_col(bar_rgb(p, m[0])), l));
                end
            end
        end

        // R10: a write outside vblank is held until vblank
        @(negedge clk) pal_mode = 1'b0;
        set_level(0);
        @(negedge clk);
        lvl_we = 1'b1; lvl_wdata = 2'd3; vblank = 1'b0; active = 1'b0;
        step();
        drive_pixel(1'b1, 1'b0, 1'b1, 7, 400, 0, 0, 0);
        check("R10 pending not applied", scale_col(base_col(7), 0));
        drive_pixel(1'b1, 1'b0, 1'b1, 6, 401, 0, 0, 0);
        check("R10 pending still held", scale_col(base_col(6), 0));
        @(negedge clk);
        vblank = 1'b1; active = 1'b0;
        step();
        drive_pixel(1'b1, 1'b0, 1'b1, 7, 402, 0, 0, 0);
        check("R10 applied at vblank", scale_col(base_col(7), 3));

        // R11: enables switch on the very next output
        for (int i = 0; i < 6; i++) begin
            drive_pixel(1'b1, i[0], i[1], 1, 300, 77, 66, 55);
            if (i[0])      check("R11 bar now", scale_col(base_col(bar_rgb(300, 1'b0)), 3));
            else if (i[1]) check("R11 overlay now", scale_col(base_col(1), 3));
            else           check("R11 image now", (77 << 16) | (66 << 8) | 55);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule